// File: doc/BRIEF.md
# Modulo 2^k−1 Prefix Adder

This block adds two k-bit operands modulo 2^k−1 in a single combinational pass. A Kogge-Stone prefix network computes the group generate and propagate signals and the ordinary binary sum of the two operands.

The group signals that cover the whole word then drive a small excess-one stage. That stage adds one to the raw sum, with wrap-around, whenever the true sum reached or passed 2^k−1. This folds the end-around carry back in without a second prefix pass.

The output always encodes zero as all zeros. An operand equal to all ones is accepted as the alternate spelling of zero. The block is meant for residue channels and for the modulo stages of residue-to-binary converters, where a 2^2n−1 channel is common. The default k of 8 matches n = 4.

Top module: `endaround_add`

## Requirements
- R1: For operands in the range 0 to 2^k−2, `sum_o` equals (a_i + b_i) mod (2^k−1).
- R2: `sum_o` never takes the all-ones value 2^k−1, for any pair of operands.
- R3: An operand of all ones (2^k−1) acts as zero: `sum_o` equals the other operand reduced mod 2^k−1, and two all-ones operands give 0.
- R4: When a_i + b_i is exactly 2^k−1, `sum_o` is 0.
- R5: With both operands at 2^k−2, `sum_o` is 2^k−3.
- R6: Swapping a_i and b_i leaves `sum_o` unchanged.
- R7: Adding 0 returns the other operand unchanged. Zero plus zero gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | K | First operand; all ones is read as zero |
| b_i | input | K | Second operand; all ones is read as zero |
| sum_o | output | K | (a_i + b_i) mod 2^K−1, zero encoded as all zeros |

## Verification
The bound checker compares `sum_o` against an arithmetic reference on every change of the operands. On each such change it also checks that the all-ones code never appears at the output, that operands summing to exactly 2^k−1 give zero, and that a zero or all-ones operand passes the other operand through. Order independence and the specific corner values can only be shown by the bench. It applies swapped operand pairs and then walks the full 2^k × 2^k operand space, including the case where both operands are all ones and the block must suppress the all-ones result.

// File: rtl/endaround_add.sv
module endaround_add #(
  parameter int K = 8
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  output logic [K-1:0] sum_o
);
  localparam int LVL = $clog2(K);

  logic [K-1:0] gt [LVL+1];
  logic [K-1:0] pt [LVL+1];
  logic [K-1:0] carry, raw, run, bumped;
  logic         inc;

  assign gt[0] = a_i & b_i;
  assign pt[0] = a_i ^ b_i;

  for (genvar lv = 0; lv < LVL; lv++) begin : g_lvl
    localparam int SPAN = 1 << lv;
    for (genvar i = 0; i < K; i++) begin : g_bit
      if (i >= SPAN) begin : g_black
        assign gt[lv+1][i] = gt[lv][i] | (pt[lv][i] & gt[lv][i-SPAN]);
        assign pt[lv+1][i] = pt[lv][i] & pt[lv][i-SPAN];
      end else begin : g_buf
        assign gt[lv+1][i] = gt[lv][i];
        assign pt[lv+1][i] = pt[lv][i];
      end
    end
  end

  assign carry = {gt[LVL][K-2:0], 1'b0};
  assign raw   = pt[0] ^ carry;

  // carry out, or raw sum all ones with nothing generated
  assign inc = gt[LVL][K-1] | pt[LVL][K-1];

  always_comb begin
    run[0] = inc;
    for (int i = 1; i < K; i++) run[i] = run[i-1] & raw[i-1];
  end

  assign bumped = raw ^ run;
  // only both-operands-all-ones reaches all ones here
  assign sum_o  = (&bumped) ? '0 : bumped;
endmodule

module endaround_add_chk #(
  parameter int K = 8
) (
  input logic [K-1:0] a_i,
  input logic [K-1:0] b_i,
  input logic [K-1:0] sum_o
);
  localparam logic [K:0] MODV = {1'b0, {K{1'b1}}};
  logic [K:0] tot, refv;
  assign tot  = {1'b0, a_i} + {1'b0, b_i};
  assign refv = tot % MODV;

  always_comb begin
    // R1
    mod_sum_chk: assert ({1'b0, sum_o} == refv)
      else $error("mod sum mismatch a=%0d b=%0d s=%0d", a_i, b_i, sum_o);
    // R2
    no_allones_chk: assert (sum_o != MODV[K-1:0])
      else $error("all-ones output a=%0d b=%0d", a_i, b_i);
    // R4
    exact_mod_zero_chk: assert (tot != MODV || sum_o == '0)
      else $error("a+b=2^k-1 not zero, s=%0d", sum_o);
    // R3
    ones_as_zero_chk: assert (b_i != MODV[K-1:0] || a_i == MODV[K-1:0] || sum_o == a_i)
      else $error("all-ones operand not zero, s=%0d", sum_o);
    // R7
    zero_ident_chk: assert (b_i != '0 || a_i == MODV[K-1:0] || sum_o == a_i)
      else $error("zero identity broken, s=%0d", sum_o);
  end
endmodule

bind endaround_add endaround_add_chk #(.K(K)) u_chk (.a_i(a_i), .b_i(b_i), .sum_o(sum_o));

// File: tb/tb_endaround_add.sv
module tb_endaround_add;
  localparam int K = 8;
  localparam int NV = 12;
  // {a, b, expected}
  localparam logic [23:0] VEC [NV] = '{
    {8'd0,   8'd0,   8'd0},    // R7
    {8'd1,   8'd2,   8'd3},    // R1
    {8'd254, 8'd1,   8'd0},    // R4
    {8'd128, 8'd127, 8'd0},    // R4
    {8'd254, 8'd254, 8'd253},  // R5
    {8'd255, 8'd7,   8'd7},    // R3
    {8'd7,   8'd255, 8'd7},    // R3
    {8'd255, 8'd255, 8'd0},    // R3 R2
    {8'd200, 8'd100, 8'd45},   // R1
    {8'd100, 8'd200, 8'd45},   // R6
    {8'd255, 8'd0,   8'd0},    // R3
    {8'd0,   8'd254, 8'd254}   // R7
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [K-1:0] a, b, s;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  endaround_add #(.K(K)) dut (.a_i(a), .b_i(b), .sum_o(s));

  task automatic check(input string req, input logic [K-1:0] exp);
    checks++;
    if (s !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, s, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    a = '0; b = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1 check("R7 reset-state zero", '0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      a = VEC[v][23:16];
      b = VEC[v][15:8];
      #1 check("R1-table", VEC[v][7:0]);
    end

    // R6: swapped pairs agree
    for (int v = 0; v < 8; v++) begin
      logic [K-1:0] first;
      @(negedge clk);
      a = 8'(v * 37 + 3); b = 8'(v * 91 + 11);
      #1 first = s;
      @(negedge clk);
      {a, b} = {b, a};
      #1 check("R6 swap", first);
    end

    // R1 R2 R3 R4 R5: full operand space
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(negedge clk);
        a = 8'(x); b = 8'(y);
        #1;
        if (x + y == 255) check("R4 exact", '0);
        else if (x == 255 || y == 255) check("R3 ones-zero", 8'((x + y) % 255));
        else check("R1 exhaustive", 8'((x + y) % 255));
        if (s == 8'hFF) check("R2 no all-ones", 8'((x + y) % 255));
      end
    end

    @(negedge clk);
    a = 8'd254; b = 8'd254;
    #1 check("R5 max pair", 8'd253);
    finish_run();
  end
endmodule